// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Engine

This block is the slave side of a two-wire serial memory holding 4096 bytes. It watches SCL and SDA and finds START, repeated START and STOP. It answers its own 7-bit device address. It serves three kinds of read: current-address reads, random reads and sequential reads. It also accepts data bytes written after an address preamble. SDA is driven open-drain through `sda_pull`, where 1 means the slave pulls the line low. The slave uses it for acknowledges and for read data.

One wrapping address counter is shared by reads and writes. A write-direction preamble of two address bytes loads the counter. A repeated START in read direction then uses it. Every byte the slave sends or stores advances the counter by one, and the counter wraps from the top address to zero. The storage is a synthesizable register file. A load port fills it before bus traffic starts.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After reset, `sda_pull` is 0 and the address counter is 0, so a current-address read returns the byte at address 0.
- R2: The first byte after a START is the device address, sent MSB first as {7-bit address, R/W}; R/W=1 means read. If the 7 address bits equal `DEV_ADDR` (default 7'h50), the slave pulls SDA low during the 9th clock. If they differ, it leaves SDA released for every following clock until the next START.
- R3: With R/W=0, the slave takes two address bytes, high byte first, and acknowledges each. The counter is loaded only when the second byte completes, so a random read works as this preamble followed by a repeated START with R/W=1.
- R4: Data leaves MSB first. `sda_pull` changes only while SCL is low, except when it is released by START or STOP. During the master's acknowledge clock the slave keeps SDA released.
- R5: If the master pulls SDA low in the acknowledge clock after a data byte, the slave sends the byte at the next address.
- R6: If the master leaves SDA high in that acknowledge clock, the read ends and SDA stays released.
- R7: A current-address read returns the byte at N+1, where N is the last address read or written.
- R8: When the counter advances from 4095 it becomes 0, and data continues from address 0.
- R9: In write direction, each byte after the two address bytes is acknowledged, stored at the counter and followed by an increment.
- R10: START or STOP aborts any transfer in progress and releases SDA. A STOP before the second address byte completes leaves the counter unchanged.
- R11: Only the low 4 bits of the high address byte are used; its upper 4 bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| load_en | input | 1 | Write strobe for preloading the array |
| load_addr | input | AW (12) | Preload address |
| load_data | input | 8 | Preload byte |

## Verification
The hardest cases are rollover and partial transfers. A sequential read that starts at 4094 must return 4094, 4095, 0 and 1. A counter that saturates would repeat the top byte, and one that carried into an unused bit would read the wrong location. A high address byte with its upper nibble set must still select the low 12 bits. The bench also aborts a preamble with STOP after one address byte. It then checks that a current read continues from the old counter, which catches an early partial load. A repeated START in the middle of a byte must resynchronise the engine. A mismatched device address must get no acknowledge and no later drive, which catches a slave that keeps answering. Finally, a read that follows a write must return the byte after the written one, which catches a counter kept separately for reads and writes.

// File: rtl/eerd_pkg.sv
// Shared types for the serial memory read engine.
package eerd_pkg;
    // Engine state: idle, receiving a byte, giving ACK, sending a byte, awaiting master ACK
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK
    } eng_state_t;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        P_DEV,
        P_AHI,
        P_ALO,
        P_WDAT
    } rx_phase_t;
endpackage

// File: rtl/eerd_line_sync.sv
// Bus line synchronizer and event detector.
// Samples SCL and SDA through STAGES flops, keeps one more delayed copy,
// and flags START, STOP and SCL edges on the synchronized levels.
// Assumes clk is at least 8x faster than SCL and STAGES >= 2.
module eerd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    // Shift both lines through the synchronizer and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    // Derive levels and edge events from the synchronized copies
    always_comb begin
        scl_lvl   = scl_sh[STAGES-1];
        sda_lvl   = sda_sh[STAGES-1];
        scl_rise  = scl_lvl & ~scl_d;
        scl_fall  = ~scl_lvl & scl_d;
        start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
        stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
    end
endmodule

// File: rtl/eerd_addr_ctr.sv
// Shared wrapping address counter. A load takes priority over an increment;
// the increment wraps from all-ones to zero.
module eerd_addr_ctr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] q
);
    // Hold, load or advance the counter
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q + AW'(1);
    end
endmodule

// File: rtl/eerd_array.sv
// Byte register file with one synchronous write port and one
// combinational read port. Contents are not reset; they are preloaded.
module eerd_array #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one byte per enabled cycle
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed byte without latency
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_reader.sv
// Two-wire serial memory slave engine.
// Receives the device address, two address bytes and write data; sends read
// bytes while the master acknowledges. One counter serves reads and writes.
// Assumes clk >= 8x SCL and that the master changes SDA only while SCL is low
// (except for START/STOP). sda_pull=1 drives the open-drain SDA low.
module i2c_eeprom_reader #(
    parameter int         AW          = 12,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [7:0]    load_data
);
    import eerd_pkg::*;

    localparam int HI_KEEP = AW - 8;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    eng_state_t    state;
    rx_phase_t     phase;
    logic [3:0]    bit_cnt, tx_cnt;
    logic [7:0]    shreg, addr_hi, tx_byte, rd_data;
    logic          is_read, mack;
    logic [AW-1:0] ctr, ld_val;
    logic          bus_evt, byte_in, dev_hit, ctr_load, ctr_inc, wr_strobe;

    eerd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    eerd_addr_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ld_val),
        .inc(ctr_inc), .q(ctr)
    );

    eerd_array #(.AW(AW), .DW(8)) u_mem (
        .clk(clk), .we(load_en | wr_strobe),
        .waddr(load_en ? load_addr : ctr),
        .wdata(load_en ? load_data : shreg),
        .raddr(ctr), .rdata(rd_data)
    );

    // Decode byte completion and counter actions for this cycle
    always_comb begin
        bus_evt   = start_det | stop_det;
        byte_in   = (state == S_RX) && scl_fall && (bit_cnt == 4'd8) && !bus_evt;
        dev_hit   = (shreg[7:1] == DEV_ADDR);
        ld_val    = {addr_hi[HI_KEEP-1:0], shreg};
        ctr_load  = byte_in && (phase == P_ALO);
        wr_strobe = byte_in && (phase == P_WDAT);
        ctr_inc   = wr_strobe ||
                    ((state == S_TX) && scl_fall && (tx_cnt == 4'd8) && !bus_evt);
    end

    // Bit-level receive/transmit sequencer and SDA driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            phase    <= P_DEV;
            bit_cnt  <= '0;
            tx_cnt   <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            tx_byte  <= '0;
            is_read  <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            state    <= S_RX;
            phase    <= P_DEV;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            state    <= S_IDLE;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_in) begin
                        if (phase != P_DEV || dev_hit) begin
                            sda_pull <= 1'b1;
                            state    <= S_ACK;
                        end else begin
                            state    <= S_IDLE;
                        end
                        if (phase == P_DEV) is_read <= shreg[0];
                        if (phase == P_AHI) addr_hi <= shreg;
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (phase == P_DEV && is_read) begin
                            sda_pull <= ~rd_data[7];
                            tx_byte  <= {rd_data[6:0], 1'b0};
                            tx_cnt   <= 4'd1;
                            state    <= S_TX;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= S_RX;
                            unique case (phase)
                                P_DEV:  phase <= P_AHI;
                                P_AHI:  phase <= P_ALO;
                                default: phase <= P_WDAT;
                            endcase
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (tx_cnt == 4'd8) begin
                            sda_pull <= 1'b0;
                            state    <= S_MACK;
                        end else begin
                            sda_pull <= ~tx_byte[7];
                            tx_byte  <= {tx_byte[6:0], 1'b0};
                            tx_cnt   <= tx_cnt + 4'd1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) mack <= ~sda_lvl;
                    if (scl_fall) begin
                        if (mack) begin
                            sda_pull <= ~rd_data[7];
                            tx_byte  <= {rd_data[6:0], 1'b0};
                            tx_cnt   <= 4'd1;
                            state    <= S_TX;
                        end else begin
                            state    <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_eeprom_reader_chk.sv
// Property checker for the serial memory engine, bound to the top module.
// Relates SDA drive to synchronized SCL events and counter moves to requests.
module i2c_eeprom_reader_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_fall,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_pull,
    input logic          ctr_inc,
    input logic          ctr_load,
    input logic [AW-1:0] ld_val,
    input logic [AW-1:0] ctr
);
    // SDA starts being driven only right after an SCL falling edge
    assert_pull_set_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // SDA is released only after an SCL fall, START or STOP
    assert_pull_drop_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

    // Bus conditions release the line
    assert_bus_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_pull);

    // Each consumed byte moves the counter by exactly one
    assert_ctr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_inc && !ctr_load) |=> (ctr == AW'($past(ctr) + AW'(1))));

    // Top address wraps to zero
    assert_ctr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_inc && !ctr_load && (ctr == {AW{1'b1}})) |=> (ctr == '0));

    // Second address byte loads the counter
    assert_ctr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_load |=> (ctr == $past(ld_val)));
endmodule

bind i2c_eeprom_reader i2c_eeprom_reader_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull), .ctr_inc(ctr_inc),
    .ctr_load(ctr_load), .ld_val(ld_val), .ctr(ctr)
);

// File: tb/sim_i2c_eeprom_reader.sv
// Bench: bus master model, table of random/sequential reads, then directed cases.
module sim_i2c_eeprom_reader;
    localparam int AW = 12;
    localparam int DEPTH = 1 << AW;
    localparam int H = 8;
    localparam logic [6:0] DEV = 7'h50;
    localparam int NVEC = 5;
    // {start address as sent (16 bits), number of bytes}
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0010, 8'd3},
        {16'h0ABC, 8'd1},
        {16'h0FFE, 8'd4},   // R8 rollover
        {16'hF123, 8'd2},   // R11 upper nibble set
        {16'h07FF, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [7:0] load_data = '0;
    wire  sda_line = sda_m & ~sda_pull;

    int n_run = 0;
    int n_fail = 0;
    int r4_viol = 0;
    logic done = 1'b0;
    logic [7:0] shadow [DEPTH];
    logic [AW-1:0] mctr = '0;
    logic pull_prev = 1'b0;

    always #5 clk = ~clk;

    i2c_eeprom_reader #(.AW(AW), .DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull(sda_pull), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return (a[7:0] * 8'd13) ^ {4'h0, a[11:8]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R4 monitor: slave drive must not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl && (sda_pull != pull_prev)) r4_viol++;
        pull_prev <= sda_pull;
    end

    task automatic bus_start;
        sda_m = 1'b1; hclk(H);
        scl = 1'b1;   hclk(H);
        sda_m = 1'b0; hclk(H);
        scl = 1'b0;   hclk(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hclk(H);
        scl = 1'b1;   hclk(H);
        sda_m = 1'b1; hclk(H);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;  hclk(H);
        scl = 1'b1; hclk(H / 2);
        seen = sda_line; hclk(H / 2);
        scl = 1'b0; hclk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(~give_ack, s);
        sda_m = 1'b1;
    endtask

    // Receive n bytes, compare to shadow at the model counter, NACK the last
    task automatic read_run(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == shadow[mctr], req, b, shadow[mctr]);
            mctr = mctr + AW'(1);
        end
        hclk(4);
        chk(sda_pull == 1'b0, "R6 released after NACK", sda_pull, 0);
        bus_stop;
    endtask

    task automatic cur_read(input int n, input string req);
        logic a;
        bus_start;
        send_byte({DEV, 1'b1}, a);
        chk(a, "R2 read address ACK", a, 1);
        read_run(n, req);
    endtask

    task automatic set_addr(input logic [15:0] ad);
        logic a;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        chk(a, "R2 write address ACK", a, 1);
        send_byte(ad[15:8], a);
        chk(a, "R3 high address ACK", a, 1);
        send_byte(ad[7:0], a);
        chk(a, "R3 low address ACK", a, 1);
        mctr = ad[AW-1:0];
    endtask

    initial begin
        hclk(150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic a, s;
        logic [7:0] b;
        hclk(5);
        rst_n = 1'b1;
        hclk(3);
        chk(sda_pull == 1'b0, "R1 reset release", sda_pull, 0);

        // Preload the array through the load port
        for (int i = 0; i < DEPTH; i++) begin
            shadow[i] = pat(AW'(i));
            load_en = 1'b1; load_addr = AW'(i); load_data = pat(AW'(i));
            hclk(1);
        end
        load_en = 1'b0;
        hclk(4);

        // R1: current read from reset counter
        cur_read(1, "R1 current read at 0");

        // Table of random/sequential reads (R3 R5 R8 R11)
        for (int v = 0; v < NVEC; v++) begin
            set_addr(VEC[v][23:8]);
            bus_start;
            send_byte({DEV, 1'b1}, a);
            chk(a, "R3 repeated START read ACK", a, 1);
            read_run(int'(VEC[v][7:0]), "R5 R8 R11 table read");
        end

        // R7: current read continues after last read (0x800)
        cur_read(2, "R7 current read after read");

        // R8 directed: single bytes across the top
        set_addr(16'h0FFF);
        bus_stop;
        cur_read(2, "R8 wrap via current read");

        // R2: mismatched device address, no ACK and no later drive
        bus_start;
        send_byte({7'h51, 1'b1}, a);
        chk(!a, "R2 mismatch no ACK", a, 0);
        send_byte(8'h00, a);
        chk(!a, "R2 silent until START", a, 0);
        bus_stop;
        cur_read(1, "R2 counter kept after mismatch");

        // R9: write two bytes at 0x200, then R7 current read returns 0x202
        set_addr(16'h0200);
        send_byte(8'hA5, a);
        chk(a, "R9 write data ACK", a, 1);
        send_byte(8'h5A, a);
        chk(a, "R9 write data ACK", a, 1);
        bus_stop;
        shadow[12'h200] = 8'hA5;
        shadow[12'h201] = 8'h5A;
        mctr = 12'h202;
        cur_read(1, "R7 current read after write");
        set_addr(16'h0200);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        read_run(2, "R9 written bytes read back");

        // R10: STOP after one address byte leaves counter alone
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h0E, a);
        bus_stop;
        hclk(4);
        chk(sda_pull == 1'b0, "R10 released after STOP", sda_pull, 0);
        cur_read(1, "R10 counter unchanged by aborted preamble");

        // R10: repeated START in the middle of a byte restarts matching
        bus_start;
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        chk(a, "R10 ACK after mid-byte START", a, 1);
        read_run(1, "R10 data after mid-byte START");

        chk(r4_viol == 0, "R4 drive changed with SCL high", r4_viol, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule